// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM read or write burst. A controller presents a start column, a burst length code and a wrap order, then pulses the start strobe. The block then presents one column per beat on registered outputs, together with a valid flag and a flag marking the final beat. An advance enable holds the current beat in place, which models a suspended clock. A terminate strobe ends the burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned group of columns that holds the start column. They wrap there either in counting order or in XOR order. A page-length burst steps through every column of the row, wraps from the top column to column 0 and runs until it is terminated. A new start is accepted on any cycle, including the cycle right after another start, and it replaces whatever burst is running.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o` and `last_o` are low after that edge.
- R2: A legal start (`start_i` high) makes `valid_o` high on the next cycle, with `col_o` equal to the `scol_i` sampled with the start. Length codes on `len_i`: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. `ilv_i` = 0 selects counting order and `ilv_i` = 1 selects XOR order.
- R3: In counting order with a burst of BL beats, beat k shows the upper bits of the start column unchanged, and its low log2(BL) bits are (start low bits + k) mod BL.
- R4: In XOR order, beat k shows the start column with its low log2(BL) bits XORed with k.
- R5: `last_o` is high exactly on beat BL-1 of a fixed burst, and on beat 0 when BL is 1. After the last beat advances with no new start, `valid_o` goes low.
- R6: A full-page burst adds one to the column on each beat, wraps from 1023 to 0 and never raises `last_o`.
- R7: A start carrying length code 4, 5 or 6, or code 7 together with XOR order, is ignored. The outputs behave as if `start_i` were low.
- R8: `term_i` without a legal start makes `valid_o` low on the next cycle.
- R9: A legal start replaces a running burst on any cycle, including back-to-back starts on consecutive cycles. A legal start wins over `term_i` in the same cycle.
- R10: While `adv_i` is low, a running burst keeps `col_o`, `valid_o` and `last_o` unchanged, and it resumes from that beat once `adv_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a new burst |
| term_i | input | 1 | End the running burst |
| adv_i | input | 1 | Advance to the next beat when high |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Wrap order: 0 counting, 1 XOR |
| scol_i | input | COL_W | Start column |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | Current column is a live beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
Interaction between events is the hardest part to reach. The cases are an illegal start arriving while a burst is mid-flight, a start landing in the same cycle as a terminate, and a freeze held across a wrap point. The stimulus first runs a table of bursts across both orders and all fixed lengths, with start columns chosen to sit at or near the wrap boundary. It then drives each of these collisions directly in the cycle just after a beat is shown, and checks the following beat against the column the requirements predict.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  localparam int unsigned MAX_FIXED_LOG = 3;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             legal_o
);
  logic fixed;

  assign fixed   = (code_i <= 3'(MAX_FIXED_LOG));
  assign page_o  = (code_i == LEN_PAGE);
  assign legal_o = fixed || (page_o && !ilv_i);

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_mask
      // bit b lies inside the wrap window when b < log2(BL)
      assign mask_o[b] = page_o ? 1'b1 : (fixed && (32'(b) < 32'(code_i)));
    end
  endgenerate
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      assign col_o[b] = mask_i[b] ? (ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b])
                                  : base_i[b];
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             adv_i,
  input  logic [2:0]       len_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] scol_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page, dec_legal;

  logic [COL_W-1:0] base_q, base_n;
  logic [COL_W-1:0] beat_q, beat_n;
  logic [COL_W-1:0] mask_q, mask_n;
  logic             ilv_q, ilv_n;
  logic             page_q, page_n;
  logic             valid_q, valid_n;
  logic             last_q, last_n;
  logic [COL_W-1:0] col_q, col_n;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_i),
    .ilv_i  (ilv_i),
    .mask_o (dec_mask),
    .page_o (dec_page),
    .legal_o(dec_legal)
  );

  always_comb begin
    base_n  = base_q;
    beat_n  = beat_q;
    mask_n  = mask_q;
    ilv_n   = ilv_q;
    page_n  = page_q;
    valid_n = valid_q;
    if (start_i && dec_legal) begin
      base_n  = scol_i;
      beat_n  = '0;
      mask_n  = dec_mask;
      ilv_n   = ilv_i;
      page_n  = dec_page;
      valid_n = 1'b1;
    end else if (term_i) begin
      valid_n = 1'b0;
    end else if (valid_q && adv_i) begin
      if (last_q) valid_n = 1'b0;
      else        beat_n  = beat_q + 1'b1;
    end
  end

  assign last_n = valid_n && !page_n && (beat_n == mask_n);

  bcg_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i(base_n),
    .beat_i(beat_n),
    .mask_i(mask_n),
    .ilv_i (ilv_n),
    .col_o (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      col_q   <= '0;
    end else begin
      base_q  <= base_n;
      beat_q  <= beat_n;
      mask_q  <= mask_n;
      ilv_q   <= ilv_n;
      page_q  <= page_n;
      valid_q <= valid_n;
      last_q  <= last_n;
      col_q   <= col_n;
    end
  end

  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             term_i,
  input logic             adv_i,
  input logic [2:0]       len_i,
  input logic             ilv_i,
  input logic [COL_W-1:0] scol_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic ok_start;
  assign ok_start = start_i && ((len_i <= 3'd3) || (len_i == 3'd7 && !ilv_i));

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!valid_o && !last_o));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    ok_start |=> (valid_o && col_o == $past(scol_i)));

  // R5
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R5
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && adv_i && !start_i && !term_i) |=> !valid_o);

  // R6
  page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_i == 3'd7 && !ilv_i) |=> !last_o);

  // R7
  bad_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !ok_start && !valid_o && !term_i) |=> !valid_o);

  // R8
  term_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (term_i && !ok_start) |=> !valid_o);

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !adv_i && !start_i && !term_i) |=>
      (valid_o && $stable(col_o) && $stable(last_o)));
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) u_bcg_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .term_i (term_i),
  .adv_i  (adv_i),
  .len_i  (len_i),
  .ilv_i  (ilv_i),
  .scol_i (scol_i),
  .col_o  (col_o),
  .valid_o(valid_o),
  .last_o (last_o)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             term_i = 1'b0;
  logic             adv_i = 1'b1;
  logic [2:0]       len_i = 3'd0;
  logic             ilv_i = 1'b0;
  logic [COL_W-1:0] scol_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .term_i(term_i), .adv_i(adv_i),
    .len_i(len_i), .ilv_i(ilv_i), .scol_i(scol_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  typedef struct packed {
    logic [9:0]       s;
    logic [2:0]       len;
    logic             ilv;
    logic [3:0]       n;
    logic [0:7][9:0]  e;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{10'h005, 3'd2, 1'b0, 4'd4, '{10'h005, 10'h006, 10'h007, 10'h004, 10'h0, 10'h0, 10'h0, 10'h0}}, // R3
    '{10'h005, 3'd2, 1'b1, 4'd4, '{10'h005, 10'h004, 10'h007, 10'h006, 10'h0, 10'h0, 10'h0, 10'h0}}, // R4
    '{10'h3FE, 3'd3, 1'b0, 4'd8, '{10'h3FE, 10'h3FF, 10'h3F8, 10'h3F9, 10'h3FA, 10'h3FB, 10'h3FC, 10'h3FD}}, // R3
    '{10'h0A3, 3'd3, 1'b1, 4'd8, '{10'h0A3, 10'h0A2, 10'h0A1, 10'h0A0, 10'h0A7, 10'h0A6, 10'h0A5, 10'h0A4}}, // R4
    '{10'h101, 3'd1, 1'b0, 4'd2, '{10'h101, 10'h100, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}}, // R3
    '{10'h101, 3'd1, 1'b1, 4'd2, '{10'h101, 10'h100, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}}, // R4
    '{10'h2AA, 3'd0, 1'b0, 4'd1, '{10'h2AA, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},   // R5
    '{10'h013, 3'd3, 1'b0, 4'd8, '{10'h013, 10'h014, 10'h015, 10'h016, 10'h017, 10'h010, 10'h011, 10'h012}}  // R3
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic beat(input string tag, input logic [9:0] ec, input bit el);
    chk(valid_o === 1'b1, {tag, " valid"}, int'(valid_o), 1);
    chk(col_o === ec, {tag, " col"}, int'(col_o), int'(ec));
    chk(last_o === el, {tag, " last"}, int'(last_o), int'(el));
  endtask

  task automatic go(input logic [9:0] s, input logic [2:0] l, input logic il);
    start_i = 1'b1; scol_i = s; len_i = l; ilv_i = il;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
    chk(last_o === 1'b0, "R1 last", int'(last_o), 0);
    rst = 1'b0;

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      go(VEC[v].s, VEC[v].len, VEC[v].ilv);
      adv_i = 1'b1;
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        @(negedge clk);
        start_i = 1'b0;
        beat($sformatf("R2/R3/R4/R5 vec%0d beat%0d", v, k), VEC[v].e[k], k == int'(VEC[v].n) - 1);
      end
      @(negedge clk);
      chk(valid_o === 1'b0, "R5 end of burst", int'(valid_o), 0);
    end

    // R6: full page wraps, never last, R8 terminate
    go(10'h3FE, 3'd7, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      beat("R6 page", 10'((32'h3FE + k) & 32'h3FF), 1'b0);
    end
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk(valid_o === 1'b0, "R8 terminate", int'(valid_o), 0);

    // R7: illegal start during a running burst is ignored
    go(10'h040, 3'd3, 1'b0);
    @(negedge clk);
    beat("R2 start", 10'h040, 1'b0);
    go(10'h200, 3'd7, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    beat("R7 ilv page ignored", 10'h041, 1'b0);

    // R9: interrupt mid burst, back to back, start beats term
    go(10'h10A, 3'd2, 1'b0);
    @(negedge clk);
    beat("R9 interrupt", 10'h10A, 1'b0);
    go(10'h055, 3'd0, 1'b0);
    @(negedge clk);
    beat("R9 back to back", 10'h055, 1'b1);
    go(10'h0C1, 3'd1, 1'b0);
    term_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    beat("R9 start over term", 10'h0C1, 1'b0);
    @(negedge clk);
    beat("R9 second beat", 10'h0C0, 1'b1);
    @(negedge clk);
    chk(valid_o === 1'b0, "R5 after last", int'(valid_o), 0);

    // R10: freeze with adv low
    go(10'h306, 3'd2, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    beat("R4 ilv start", 10'h306, 1'b0);
    adv_i = 1'b0;
    @(negedge clk);
    beat("R10 hold 1", 10'h306, 1'b0);
    @(negedge clk);
    beat("R10 hold 2", 10'h306, 1'b0);
    adv_i = 1'b1;
    @(negedge clk);
    beat("R10 resume", 10'h307, 1'b0);
    adv_i = 1'b0;
    @(negedge clk);
    beat("R10 hold 3", 10'h307, 1'b0);
    adv_i = 1'b1;
    @(negedge clk);
    beat("R10 b2", 10'h304, 1'b0);
    adv_i = 1'b0;
    @(negedge clk);
    adv_i = 1'b1;
    beat("R10 hold 4", 10'h304, 1'b0);
    @(negedge clk);
    adv_i = 1'b0;
    beat("R10 b3", 10'h305, 1'b1);
    @(negedge clk);
    adv_i = 1'b1;
    beat("R10 hold on last", 10'h305, 1'b1);
    @(negedge clk);
    chk(valid_o === 1'b0, "R5 end after hold", int'(valid_o), 0);

    // R7: reserved code while idle
    go(10'h123, 3'd5, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b0, "R7 reserved code", int'(valid_o), 0);

    // R1: reset mid burst
    go(10'h011, 3'd3, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(valid_o === 1'b0 && last_o === 1'b0, "R1 reset mid burst", int'(valid_o), 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule